// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is a 16-bit down-counter with its own reload register. A start trigger copies the reload value into the counter and begins counting. The counter then steps down by one on every count tick. The tick comes from the system clock divided by 2, 8 or 32. It can also come from an external event line, which is synchronized and edge-detected. The step from 0x0000 to 0xFFFF is an underflow, so a reload value R gives an interval of R+1 ticks. An underflow sets an interrupt flag. The timer then either halts (one-shot) or reloads itself and keeps running (reload mode).

The timer output has two forms. In one-shot mode it is a rectangular level that stays active for as long as the counter runs. In reload mode it is a square wave that inverts at every underflow. A level-select bit sets the polarity in both modes.

Software uses a two-entry write port. Select 0 writes the control word and select 1 writes the reload register. The control word has these fields:
- bit 0: enable
- bit 1: software trigger (self-clearing)
- bit 2: reload mode
- bit 3: output level
- bit 4: interrupt enable
- bit 5: flag (write 0 to clear)
- bits 7:6: tick source, where 0 is /2, 1 is /8, 2 is /32 and 3 is the event input
- bits 9:8: event edge, where 01 is rising, 10 is falling, 11 is both and 00 is none

Top module: `reload_timer`

## Requirements
- R1: After reset the outputs read as follows: `count`=0, `running`=0, `irqFlag`=0, `irq`=0 and `timerOut`=0. All control fields are 0.
- R2: A start happens on a control write with bit 0 and bit 1 both set, or on `trigIn`=1 while the stored enable is 1. A start loads `count` with the reload value at that edge, sets `running`, clears the divider phase and clears the toggle state. A start while the counter is running restarts it from the reload value.
- R3: With an internal source of divide d (2, 8 or 32 for source codes 0, 1, 2), `count` decrements at edges E+d, E+2d and so on after a start edge E. The underflow (0x0000 to 0xFFFF) happens at edge E+d·(R+1).
- R4: In one-shot mode (bit 2 = 0), an underflow clears `running` and `count` holds 0xFFFF.
- R5: In reload mode (bit 2 = 1), an underflow loads `count` with the reload value and `running` stays 1.
- R6: In one-shot mode `timerOut` equals `running` XOR the output-level bit.
- R7: In reload mode `timerOut` equals the toggle state XOR the output-level bit. The toggle state is 0 after a start and inverts at every underflow.
- R8: An underflow sets `irqFlag`. A control write with bit 5 = 0 clears it. A control write with bit 5 = 1 leaves it unchanged. If an underflow and a clearing write fall in the same cycle, the underflow wins.
- R9: `irq` is 1 exactly when `irqFlag` is 1 and the interrupt-enable bit is 1.
- R10: In event mode (source 3), the event input passes through a two-stage synchronizer. Each edge of the kind selected by bits 9:8 decrements a running counter once. Edges of the kind not selected have no effect on `count`.
- R11: With the enable bit at 0, `trigIn` and software triggers are ignored. Writing the enable bit to 0 clears `running` at that edge, and `count` then holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 selects the control word, 1 selects the reload register |
| wrData | input | 16 | Write data |
| trigIn | input | 1 | Hardware start trigger, one cycle, synchronous |
| eventIn | input | 1 | Asynchronous external event line |
| count | output | 16 | Current counter value |
| running | output | 1 | Counter is active |
| irqFlag | output | 1 | Underflow flag |
| irq | output | 1 | Interrupt request |
| timerOut | output | 1 | Timer output pin |

## Verification
The assertions check the cycle-local rules on every clock:
- a one-shot underflow stops the counter at 0xFFFF;
- a reload underflow reloads the counter and keeps it running;
- the count holds between ticks and steps by exactly one on a tick;
- every underflow sets the flag;
- the output inverts at each reload-mode underflow;
- a disabled timer stays idle.

Some behaviours only the bench scenarios can show. These are the absolute interval of d·(R+1) cycles for each divider, the synchronizer latency and edge selection in event mode, retrigger restart, and flag clear-versus-ignore on writes.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int CFG_W      = 10;
  localparam int B_EN       = 0;
  localparam int B_TRIG     = 1;
  localparam int B_MODE     = 2;
  localparam int B_LVL      = 3;
  localparam int B_IRQEN    = 4;
  localparam int B_FLAG     = 5;
  localparam int B_SRC_LO   = 6;
  localparam int B_EDGE_LO  = 8;

  typedef enum logic [1:0] {
    SRC_DIV_A = 2'd0,
    SRC_DIV_B = 2'd1,
    SRC_DIV_C = 2'd2,
    SRC_EVENT = 2'd3
  } tick_src_e;

  typedef struct packed {
    logic load;      // copy reload value into counter
    logic dec;       // decrement counter
    logic wrReload;  // write reload register
  } rt_strobe_t;
endpackage

// File: rtl/rt_tick_gen.sv
module rt_tick_gen
  import rt_pkg::*;
#(
  parameter int DIV_A_LOG   = 1,
  parameter int DIV_B_LOG   = 3,
  parameter int DIV_C_LOG   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      clrPre,
  input  tick_src_e src,
  input  logic [1:0] edgeSel,
  input  logic      eventIn,
  output logic      tick
);
  localparam int PRE_W = DIV_C_LOG;
  localparam logic [PRE_W-1:0] MASK_A = PRE_W'((1 << DIV_A_LOG) - 1);
  localparam logic [PRE_W-1:0] MASK_B = PRE_W'((1 << DIV_B_LOG) - 1);
  localparam logic [PRE_W-1:0] MASK_C = PRE_W'((1 << DIV_C_LOG) - 1);

  logic [PRE_W-1:0] pre;
  logic [SYNC_STAGES-1:0] syncQ;
  logic evSync, evPrev, evRise, evFall, evTick;
  logic [PRE_W-1:0] selMask;

  always_ff @(posedge clk) begin
    if (!rstN)       pre <= '0;
    else if (clrPre) pre <= '0;
    else             pre <= pre + 1'b1;
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= eventIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], eventIn};
      end
    end
  endgenerate

  assign evSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) evPrev <= 1'b0;
    else       evPrev <= evSync;
  end

  assign evRise = evSync & ~evPrev;
  assign evFall = ~evSync & evPrev;
  assign evTick = (edgeSel[0] & evRise) | (edgeSel[1] & evFall);

  always_comb begin
    unique case (src)
      SRC_DIV_A: selMask = MASK_A;
      SRC_DIV_B: selMask = MASK_B;
      default:   selMask = MASK_C;
    endcase
  end

  assign tick = (src == SRC_EVENT) ? evTick : ((pre & selMask) == selMask);
endmodule

// File: rtl/rt_datapath.sv
module rt_datapath
  import rt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  rt_strobe_t       strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reloadVal,
  output logic             isZero
);
  always_ff @(posedge clk) begin
    if (!rstN)              reloadVal <= '0;
    else if (strb.wrReload) reloadVal <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         count <= '0;
    else if (strb.load) count <= reloadVal;
    else if (strb.dec)  count <= count - 1'b1;
  end

  assign isZero = (count == '0);
endmodule

// File: rtl/rt_ctrl.sv
module rt_ctrl
  import rt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             trigIn,
  input  logic             tick,
  input  logic             isZero,
  output rt_strobe_t       strb,
  output logic             underflow,
  output logic             startReq,
  output logic             clrPre,
  output tick_src_e        src,
  output logic [1:0]       edgeSel,
  output logic             cfgEn,
  output logic             cfgMode,
  output logic             running,
  output logic             irqFlag,
  output logic             irq,
  output logic             timerOut
);
  logic ctrlWr, enNext, active, toggleQ;
  logic outLvl, irqEn;

  assign ctrlWr = wrEn & ~wrSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEn   <= 1'b0;
      cfgMode <= 1'b0;
      outLvl  <= 1'b0;
      irqEn   <= 1'b0;
      src     <= SRC_DIV_A;
      edgeSel <= 2'b00;
    end else if (ctrlWr) begin
      cfgEn   <= cfgData[B_EN];
      cfgMode <= cfgData[B_MODE];
      outLvl  <= cfgData[B_LVL];
      irqEn   <= cfgData[B_IRQEN];
      src     <= tick_src_e'(cfgData[B_SRC_LO +: 2]);
      edgeSel <= cfgData[B_EDGE_LO +: 2];
    end
  end

  assign enNext    = ctrlWr ? cfgData[B_EN] : cfgEn;
  assign startReq  = (ctrlWr & cfgData[B_TRIG] & cfgData[B_EN]) | (trigIn & cfgEn);
  assign active    = running & cfgEn;
  assign underflow = active & tick & isZero & ~startReq;
  assign clrPre    = startReq;

  always_comb begin
    strb          = '0;
    strb.wrReload = wrEn & wrSel;
    strb.load     = startReq | (underflow & cfgMode);
    strb.dec      = active & tick & ~startReq & ~(underflow & cfgMode);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                       running <= 1'b0;
    else if (startReq)               running <= 1'b1;
    else if (!enNext)                running <= 1'b0;
    else if (underflow && !cfgMode)  running <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      toggleQ <= 1'b0;
    else if (startReq)              toggleQ <= 1'b0;
    else if (underflow && cfgMode)  toggleQ <= ~toggleQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          irqFlag <= 1'b0;
    else if (underflow)                 irqFlag <= 1'b1;
    else if (ctrlWr && !cfgData[B_FLAG]) irqFlag <= 1'b0;
  end

  assign irq      = irqFlag & irqEn;
  assign timerOut = (cfgMode ? toggleQ : running) ^ outLvl;
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_A_LOG   = 1,
  parameter int DIV_B_LOG   = 3,
  parameter int DIV_C_LOG   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             trigIn,
  input  logic             eventIn,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             irqFlag,
  output logic             irq,
  output logic             timerOut
);
  rt_strobe_t       strb;
  logic             underflow, startReq, clrPre, tick, isZero;
  logic             cfgEn, cfgMode;
  tick_src_e        src;
  logic [1:0]       edgeSel;
  logic [CNT_W-1:0] reloadVal;

  rt_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .cfgData(wrData[CFG_W-1:0]), .trigIn(trigIn), .tick(tick), .isZero(isZero),
    .strb(strb), .underflow(underflow), .startReq(startReq), .clrPre(clrPre),
    .src(src), .edgeSel(edgeSel), .cfgEn(cfgEn), .cfgMode(cfgMode),
    .running(running), .irqFlag(irqFlag), .irq(irq), .timerOut(timerOut)
  );

  rt_tick_gen #(
    .DIV_A_LOG(DIV_A_LOG), .DIV_B_LOG(DIV_B_LOG),
    .DIV_C_LOG(DIV_C_LOG), .SYNC_STAGES(SYNC_STAGES)
  ) i_tick (
    .clk(clk), .rstN(rstN), .clrPre(clrPre), .src(src),
    .edgeSel(edgeSel), .eventIn(eventIn), .tick(tick)
  );

  rt_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .count(count), .reloadVal(reloadVal), .isZero(isZero)
  );
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             trigIn,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reloadVal,
  input logic             running,
  input logic             irqFlag,
  input logic             irq,
  input logic             timerOut,
  input logic             cfgEn,
  input logic             cfgMode,
  input logic             underflow,
  input logic             startReq,
  input logic             tick
);
  p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !cfgMode) |=> (!running && count == {CNT_W{1'b1}}));

  p_reload_cont_r5: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && cfgMode && !wrEn) |=> (running && count == $past(reloadVal)));

  p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!(tick && running) && !startReq) |=> $stable(count));

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && running && cfgEn && !startReq && count != '0) |=> (count == $past(count) - 1'b1));

  p_flag_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> irqFlag);

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> irqFlag);

  p_toggle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && cfgMode && !wrEn && !trigIn) |=> (timerOut != $past(timerOut)));

  p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEn && !wrEn) |=> !running);
endmodule

bind reload_timer rt_checker #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .trigIn(trigIn),
  .count(count), .reloadVal(reloadVal), .running(running),
  .irqFlag(irqFlag), .irq(irq), .timerOut(timerOut),
  .cfgEn(cfgEn), .cfgMode(cfgMode), .underflow(underflow),
  .startReq(startReq), .tick(tick)
);

// File: tb/test_reload_timer.sv
module test_reload_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic        trigIn = 1'b0;
  logic        eventIn = 1'b0;
  logic [15:0] count;
  logic        running, irqFlag, irq, timerOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  reload_timer i_reload_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .trigIn(trigIn), .eventIn(eventIn), .count(count), .running(running),
    .irqFlag(irqFlag), .irq(irq), .timerOut(timerOut)
  );

  // vector: reload[19:4], src[3:2], mode[1], level[0]
  localparam int NVEC = 6;
  localparam logic [19:0] VEC [NVEC] = '{
    {16'd3, 2'd0, 1'b0, 1'b0},
    {16'd0, 2'd0, 1'b1, 1'b0},
    {16'd2, 2'd1, 1'b0, 1'b1},
    {16'd1, 2'd2, 1'b1, 1'b1},
    {16'd5, 2'd0, 1'b1, 1'b0},
    {16'd0, 2'd1, 1'b0, 1'b0}
  };

  function automatic logic [15:0] cfgWord(logic en, logic trg, logic md, logic lv,
                                          logic ie, logic fl, logic [1:0] sr, logic [1:0] ed);
    return {6'b0, ed, sr, fl, ie, lv, md, trg, en};
  endfunction

  function automatic int divOf(logic [1:0] sr);
    return (sr == 2'd0) ? 2 : (sr == 2'd1) ? 8 : 32;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic sel, logic [15:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulseTrig();
    @(negedge clk); trigIn = 1'b1;
    @(negedge clk); trigIn = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 running", running, 0);
    check("R1 irqFlag", irqFlag, 0);
    check("R1 irq", irq, 0);
    check("R1 timerOut", timerOut, 0);

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] rv;
      logic [1:0]  sr;
      logic        md, lv;
      int          el, expEl;
      rv = VEC[v][19:4]; sr = VEC[v][3:2]; md = VEC[v][1]; lv = VEC[v][0];
      expEl = divOf(sr) * (int'(rv) + 1);
      regWrite(1'b1, rv);
      regWrite(1'b0, cfgWord(1, 1, md, lv, 1, 0, sr, 2'b01));
      check("R2 load", count, rv);
      check("R2 running", running, 1);
      check(md ? "R7 start level" : "R6 active level", timerOut, md ? lv : !lv);
      el = 0;
      while (!irqFlag && el < 5000) begin
        @(negedge clk); el++;
      end
      check("R3 interval", el, expEl);
      check("R9 irq on", irq, 1);
      if (!md) begin
        check("R4 stopped", running, 0);
        check("R4 count", count, 16'hFFFF);
        check("R6 idle level", timerOut, lv);
      end else begin
        check("R5 running", running, 1);
        check("R5 reloaded", count, rv);
        check("R7 toggled", timerOut, !lv);
      end
    end

    // R8 / R9: write 1 leaves flag, irq gated by enable
    regWrite(1'b0, cfgWord(1, 0, 0, 0, 0, 1, 2'd0, 2'b01));
    check("R8 write1 keeps flag", irqFlag, 1);
    check("R9 irq masked", irq, 0);
    regWrite(1'b0, cfgWord(1, 0, 0, 0, 0, 0, 2'd0, 2'b01));
    check("R8 write0 clears", irqFlag, 0);

    // R11: triggers ignored while disabled
    regWrite(1'b0, cfgWord(0, 1, 0, 0, 0, 0, 2'd0, 2'b01));
    check("R11 sw trig ignored", running, 0);
    pulseTrig();
    check("R11 hw trig ignored", running, 0);

    // R2 retrigger restart, R3 step timing
    regWrite(1'b1, 16'd10);
    regWrite(1'b0, cfgWord(1, 1, 0, 0, 1, 0, 2'd0, 2'b01));
    repeat (8) @(negedge clk);
    check("R3 after 8 cycles", count, 6);
    pulseTrig();
    check("R2 retrigger reload", count, 10);
    begin
      int el = 0;
      while (!irqFlag && el < 5000) begin
        @(negedge clk); el++;
      end
      check("R2 retrigger interval", el, 22);
    end

    // R11: disabling halts a running counter
    regWrite(1'b1, 16'd20);
    regWrite(1'b0, cfgWord(1, 1, 1, 0, 0, 0, 2'd0, 2'b01));
    repeat (4) @(negedge clk);
    regWrite(1'b0, cfgWord(0, 0, 1, 0, 0, 0, 2'd0, 2'b01));
    check("R11 halted", running, 0);
    begin
      logic [15:0] held;
      held = count;
      repeat (6) @(negedge clk);
      check("R11 count holds", count, held);
    end

    // R7: two successive underflows in reload mode
    regWrite(1'b1, 16'd1);
    regWrite(1'b0, cfgWord(1, 1, 1, 0, 0, 0, 2'd0, 2'b01));
    repeat (4) @(negedge clk);
    check("R7 first underflow", timerOut, 1);
    repeat (4) @(negedge clk);
    check("R7 second underflow", timerOut, 0);

    // R10: event mode, rising edge
    regWrite(1'b1, 16'd2);
    regWrite(1'b0, cfgWord(1, 1, 0, 0, 0, 0, 2'd3, 2'b01));
    @(negedge clk); eventIn = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 rising counted", count, 1);
    eventIn = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 falling ignored", count, 1);

    // R10: event mode, falling edge selected
    regWrite(1'b0, cfgWord(1, 1, 0, 0, 0, 0, 2'd3, 2'b10));
    @(negedge clk); eventIn = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 rising ignored", count, 2);
    eventIn = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 falling counted", count, 1);

    done = 1'b1;
    finishRun();
  end
endmodule